// File: doc/BRIEF.md
# DRAM Refresh and Power-up Initialiser

This block takes an asynchronous DRAM from power-up to operational state and then keeps its contents valid. After reset it stays silent for a programmable pause. It then runs a fixed number of warm-up refresh cycles and only after that raises `ready`. The access sequencer must not start any memory access while `ready` is low.

In normal operation an interval timer creates one refresh demand per refresh interval. Demands wait in a small saturating backlog. The block asks for the shared strobes and address bus with `ref_req`. It starts a refresh cycle only when `ref_gnt` is high, and it drives the bus only while a cycle is in progress. A demand that cannot be stored because the backlog is full is reported on `ref_lost`.

A build-time parameter selects the refresh style:
- Column-strobe-first: the column strobe falls before the row strobe, and the address is unused.
- Row-only: an internal row counter is placed on the address bus and only the row strobe pulses.

Top module: `dram_refresh_init`

## Requirements
- R1: While reset is held and directly after it, `ras_n`, `cas_n` and `we_n` are 1, `drive_en`, `ref_req`, `ready` and `ref_lost` are 0 and `addr` is 0.
- R2: After reset release, `ref_req` first goes high when PAUSE_CYC clock cycles have elapsed, and not before.
- R3: Exactly INIT_CYC refresh cycles complete before `ready` rises. Once high, `ready` never falls until the next reset.
- R4: Once ready, with grants given at once, successive refresh cycles start exactly INTERVAL_CYC clock cycles apart.
- R5: In column-strobe-first mode (USE_CBR=1):
  - `cas_n` goes low at least T_LEAD cycles before `ras_n` falls.
  - `cas_n` stays low while `ras_n` is low.
  - `cas_n` returns high in the same cycle as `ras_n`.
  - `addr` stays 0.
- R6: In row-only mode (USE_CBR=0):
  - `cas_n` stays high.
  - During each cycle, `addr` carries the row counter in its low ROW_BITS bits.
  - The row counter starts at 0 after reset and advances by one per cycle, modulo 2^ROW_BITS.
- R7: `ras_n` is low for exactly T_RASW cycles per refresh and stays high for at least T_PRE cycles between refreshes.
- R8: `we_n` is always 1. `drive_en` is high only while `ref_gnt` is high. While `drive_en` is low, `ras_n` and `cas_n` are 1 and `addr` is 0.
- R9: While grants are withheld, no refresh starts. Up to BACKLOG_MAX demands are kept. After the grant returns they are served back to back, one cycle start every T_LEAD+T_RASW+T_PRE+1 cycles (T_LEAD counts only in column-strobe-first mode).
- R10: A timer demand that arrives while the backlog holds BACKLOG_MAX produces a one-cycle `ref_lost` pulse and is not served later.
- R11: `ref_req` is high whenever a demand is pending or a refresh cycle is in progress. No cycle starts without `ref_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_req | output | 1 | Request for the shared memory bus |
| ref_gnt | input | 1 | Bus granted to the refresh block; held until `ref_req` falls |
| ready | output | 1 | Memory initialised; accesses may begin |
| ref_lost | output | 1 | One-cycle pulse: a refresh demand found the backlog full |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| drive_en | output | 1 | Block is driving the strobes and address |
| addr | output | ADDR_W | Row address in row-only mode, else 0 |

## Verification
A wrong phase or pause count shows at the ports at once: `ref_req` rises on the wrong cycle, or `ready` rises after the wrong number of row-strobe pulses.

A wrong backlog count appears within one grant release. Either the number of catch-up pulses after withholding differs, or the number of `ref_lost` pulses does not match.

Row counter faults show at the first affected refresh, because the scoreboard compares every row address in order across the wrap. Strobe ordering and width faults are caught on the first cycle in which they occur.

// File: rtl/dref_pkg.sv
package dref_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_ACT, SQ_PRE} sq_state_e;
    typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
endpackage

// File: rtl/dref_tick.sv
module dref_tick #(
    parameter int INTERVAL_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (en) begin
            if (cnt_q == '0) begin
                tick  = 1'b1;
                cnt_d = TW'(INTERVAL_CYC - 1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TW'(INTERVAL_CYC - 1);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter bit USE_CBR  = 1'b1,
    parameter int ROW_BITS = 13,
    parameter int ADDR_W   = 13,
    parameter int T_LEAD   = 1,
    parameter int T_RASW   = 3,
    parameter int T_PRE    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              drive_en,
    output logic [ADDR_W-1:0] addr
);
    localparam int TM1  = (T_LEAD > T_RASW) ? T_LEAD : T_RASW;
    localparam int TMAX = (TM1 > T_PRE) ? TM1 : T_PRE;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        sq_state_e           st;
        logic [CW-1:0]       cnt;
        logic [ROW_BITS-1:0] row;
    } seq_s;

    seq_s d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.st)
            SQ_IDLE: if (start) begin
                if (USE_CBR) begin
                    d.st  = SQ_LEAD;
                    d.cnt = CW'(T_LEAD - 1);
                end else begin
                    d.st  = SQ_ACT;
                    d.cnt = CW'(T_RASW - 1);
                end
            end
            SQ_LEAD: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_ACT;
                    d.cnt = CW'(T_RASW - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            SQ_ACT: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_PRE;
                    d.cnt = CW'(T_PRE - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            SQ_PRE: begin
                if (q.cnt == '0) begin
                    d.st = SQ_IDLE;
                    done = 1'b1;
                    if (!USE_CBR) d.row = q.row + 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE, cnt: '0, row: '0};
        else        q <= d;
    end

    assign busy     = (q.st != SQ_IDLE);
    assign drive_en = busy;
    assign ras_n    = (q.st != SQ_ACT);
    assign we_n     = 1'b1;

    generate
        if (USE_CBR) begin : g_cbr
            assign cas_n = !(q.st == SQ_LEAD || q.st == SQ_ACT);
            assign addr  = '0;
        end else begin : g_ror
            assign cas_n = 1'b1;
            assign addr  = drive_en ? ADDR_W'(q.row) : '0;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_init.sv
module dram_refresh_init
    import dref_pkg::*;
#(
    parameter bit USE_CBR      = 1'b1,
    parameter int ADDR_W       = 13,
    parameter int ROW_BITS     = 13,
    parameter int PAUSE_CYC    = 10000,
    parameter int INIT_CYC     = 8,
    parameter int INTERVAL_CYC = 780,
    parameter int BACKLOG_MAX  = 4,
    parameter int T_LEAD       = 1,
    parameter int T_RASW       = 3,
    parameter int T_PRE        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ref_req,
    input  logic              ref_gnt,
    output logic              ready,
    output logic              ref_lost,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              drive_en,
    output logic [ADDR_W-1:0] addr
);
    localparam int PW   = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam int PMAX = (INIT_CYC > BACKLOG_MAX) ? INIT_CYC : BACKLOG_MAX;
    localparam int NW   = $clog2(PMAX + 1);
    localparam int IW   = $clog2(INIT_CYC + 1);

    typedef struct packed {
        phase_e        phase;
        logic [PW-1:0] pcnt;
        logic [NW-1:0] pend;
        logic [IW-1:0] init_left;
        logic          ready;
        logic          lost;
    } top_s;

    top_s d, q;
    logic seq_busy, seq_done, seq_start, tick;

    assign seq_start = (q.pend != '0) && ref_gnt && !seq_busy;

    dref_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.phase == PH_RUN),
        .tick (tick)
    );

    dref_seq #(
        .USE_CBR (USE_CBR),
        .ROW_BITS(ROW_BITS),
        .ADDR_W  (ADDR_W),
        .T_LEAD  (T_LEAD),
        .T_RASW  (T_RASW),
        .T_PRE   (T_PRE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seq_start),
        .busy    (seq_busy),
        .done    (seq_done),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .drive_en(drive_en),
        .addr    (addr)
    );

    always_comb begin
        d      = q;
        d.lost = 1'b0;
        unique case (q.phase)
            PH_PAUSE: begin
                if (q.pcnt == '0) begin
                    d.phase = PH_INIT;
                    d.pend  = NW'(INIT_CYC);
                end else d.pcnt = q.pcnt - 1'b1;
            end
            PH_INIT: begin
                if (seq_start) d.pend = q.pend - 1'b1;
                if (seq_done) begin
                    d.init_left = q.init_left - 1'b1;
                    if (q.init_left == IW'(1)) begin
                        d.phase = PH_RUN;
                        d.ready = 1'b1;
                    end
                end
            end
            PH_RUN: begin
                unique case ({tick, seq_start})
                    2'b10: begin
                        if (q.pend == NW'(BACKLOG_MAX)) d.lost = 1'b1;
                        else                            d.pend = q.pend + 1'b1;
                    end
                    2'b01:   d.pend = q.pend - 1'b1;
                    default: d.pend = q.pend;
                endcase
            end
            default: d.phase = PH_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_PAUSE, pcnt: PW'(PAUSE_CYC - 1), pend: '0,
                           init_left: IW'(INIT_CYC), ready: 1'b0, lost: 1'b0};
        else        q <= d;
    end

    assign ref_req  = (q.pend != '0) || seq_busy;
    assign ready    = q.ready;
    assign ref_lost = q.lost;
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
    parameter bit USE_CBR = 1'b1,
    parameter int ADDR_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_req,
    input logic              ref_gnt,
    input logic              ready,
    input logic              ref_lost,
    input logic              ras_n,
    input logic              cas_n,
    input logic              drive_en,
    input logic [ADDR_W-1:0] addr
);
    a_r8_drive_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ref_gnt);
    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (ras_n && cas_n && addr == '0));
    a_r11_req_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ref_req);
    a_r5_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_CBR && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));
    a_r6_cas_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!USE_CBR && !ras_n) |-> cas_n);
    a_r7_ras_not_single: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);
    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    a_r10_lost_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost |-> ready);
endmodule

bind dram_refresh_init dref_checker #(.USE_CBR(USE_CBR), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_req (ref_req),
    .ref_gnt (ref_gnt),
    .ready   (ready),
    .ref_lost(ref_lost),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .drive_en(drive_en),
    .addr    (addr)
);

// File: tb/test_dram_refresh_init.sv
module test_dram_refresh_init;
    localparam int AW = 13, RB = 3, PAUSE = 20, INIT = 8, IVL = 40, BMAX = 3;
    localparam int TL = 1, TR = 3, TP = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic allow_c = 1'b1, allow_r = 1'b1;
    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 1'b0;

    logic c_req, c_gnt, c_rdy, c_lost, c_ras, c_cas, c_we, c_drv;
    logic r_req, r_gnt, r_rdy, r_lost, r_ras, r_cas, r_we, r_drv;
    logic [AW-1:0] c_addr, r_addr;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign c_gnt = c_req & (allow_c | c_drv);
    assign r_gnt = r_req & (allow_r | r_drv);

    dram_refresh_init #(.USE_CBR(1'b1), .ADDR_W(AW), .ROW_BITS(RB), .PAUSE_CYC(PAUSE),
        .INIT_CYC(INIT), .INTERVAL_CYC(IVL), .BACKLOG_MAX(BMAX), .T_LEAD(TL),
        .T_RASW(TR), .T_PRE(TP)) i_dram_refresh_init (
        .clk(clk), .rst_n(rst_n), .ref_req(c_req), .ref_gnt(c_gnt), .ready(c_rdy),
        .ref_lost(c_lost), .ras_n(c_ras), .cas_n(c_cas), .we_n(c_we),
        .drive_en(c_drv), .addr(c_addr));

    dram_refresh_init #(.USE_CBR(1'b0), .ADDR_W(AW), .ROW_BITS(RB), .PAUSE_CYC(PAUSE),
        .INIT_CYC(INIT), .INTERVAL_CYC(IVL), .BACKLOG_MAX(BMAX), .T_LEAD(TL),
        .T_RASW(TR), .T_PRE(TP)) i_dram_refresh_init_ror (
        .clk(clk), .rst_n(rst_n), .ref_req(r_req), .ref_gnt(r_gnt), .ready(r_rdy),
        .ref_lost(r_lost), .ras_n(r_ras), .cas_n(r_cas), .we_n(r_we),
        .drive_en(r_drv), .addr(r_addr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard of expected row addresses
    int exp_q[$];
    task automatic push_rows(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(i % (1 << RB));
    endtask

    // monitor: column-strobe-first instance
    logic c_pras = 1'b1, c_pcas = 1'b1;
    int c_low = 0, c_high = 0, c_falls = 0, c_last = 0, c_prev = 0, c_lostn = 0;
    always @(negedge clk) if (rst_n) begin
        if (c_lost) c_lostn++;
        if (!c_drv) chk(c_ras && c_cas && c_addr == 0, "R8 idle bus", c_ras, 1);
        if (c_drv)  chk(c_gnt == 1'b1, "R8 drive without grant", c_gnt, 1);
        if (!c_ras) begin
            if (c_pras) begin
                chk(!c_cas && !c_pcas, "R5 column strobe lead", c_pcas, 0);
                chk(c_we && c_addr == 0, "R5/R8 we_n high, addr zero", c_addr, 0);
                if (c_falls > 0) chk(c_high >= TP, "R7 precharge", c_high, TP);
                c_falls++; c_prev = c_last; c_last = cyc; c_low = 1;
            end else begin
                c_low++;
                chk(!c_cas, "R5 column strobe held", c_cas, 0);
            end
        end else begin
            if (!c_pras) begin
                chk(c_low == TR, "R7 row pulse width", c_low, TR);
                chk(c_cas == 1'b1, "R5 column strobe release", c_cas, 1);
                c_high = 1;
            end else c_high++;
        end
        c_pras = c_ras; c_pcas = c_cas;
    end

    // monitor: row-only instance
    logic r_pras = 1'b1;
    int r_low = 0, r_high = 0, r_falls = 0, r_last = 0, r_prev = 0, r_lostn = 0;
    always @(negedge clk) if (rst_n) begin
        if (r_lost) r_lostn++;
        if (!r_drv) chk(r_ras && r_cas && r_addr == 0, "R8 idle bus", r_ras, 1);
        if (r_drv)  chk(r_gnt == 1'b1 && r_we == 1'b1, "R8 grant and we_n", r_gnt, 1);
        if (!r_ras) begin
            chk(r_cas == 1'b1, "R6 column strobe stays high", r_cas, 1);
            if (r_pras) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected row refresh", r_addr, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(r_addr == AW'(e), "R6 row address", r_addr, e);
                end
                if (r_falls > 0) chk(r_high >= TP, "R7 precharge", r_high, TP);
                r_falls++; r_prev = r_last; r_last = cyc; r_low = 1;
            end else r_low++;
        end else begin
            if (!r_pras) begin
                chk(r_low == TR, "R7 row pulse width", r_low, TR);
                r_high = 1;
            end else r_high++;
        end
        r_pras = r_ras;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int n, f;
        push_rows(64);
        repeat (3) step();
        // R1 reset state
        chk(c_ras && c_cas && c_we && !c_drv && c_addr == 0, "R1 strobes in reset", c_ras, 1);
        chk(!c_req && !c_rdy && !c_lost, "R1 req/ready in reset", c_req, 0);
        chk(r_ras && r_cas && r_we && !r_drv && r_addr == 0 && !r_req && !r_rdy,
            "R1 row-only reset", r_req, 0);
        rst_n = 1'b1;
        // R2 pause
        n = 0;
        do begin step(); n++; end while (!c_req && n < 1000);
        chk(n == PAUSE, "R2 pause length", n, PAUSE);
        chk(r_req == 1'b1, "R2 row-only request", r_req, 1);
        chk(!c_rdy && !r_rdy, "R3 not ready during init", c_rdy, 0);
        // R3 init count
        while (!c_rdy) step();
        chk(c_falls == INIT, "R3 init cycles before ready", c_falls, INIT);
        chk(r_rdy == 1'b1 && r_falls == INIT, "R3 row-only init cycles", r_falls, INIT);
        // R4 steady interval
        while (c_falls < INIT + 3 || r_falls < INIT + 3) step();
        chk(c_last - c_prev == IVL, "R4 interval column-first", c_last - c_prev, IVL);
        chk(r_last - r_prev == IVL, "R4 interval row-only", r_last - r_prev, IVL);
        // R9 backlog catch-up on row-only instance
        f = r_falls;
        while (r_falls == f) step();
        allow_r = 1'b0;
        f = r_falls;
        repeat (2 * IVL) step();
        chk(r_falls == f, "R9 no refresh while withheld", r_falls, f);
        chk(r_req == 1'b1, "R11 request while pending", r_req, 1);
        allow_r = 1'b1;
        repeat (20) step();
        chk(r_falls == f + 2, "R9 catch-up count", r_falls, f + 2);
        chk(r_last - r_prev == TR + TP + 1, "R9 back-to-back spacing", r_last - r_prev, TR + TP + 1);
        chk(r_lostn == 0, "R10 no loss below limit", r_lostn, 0);
        // R10 overrun
        f = r_falls;
        while (r_falls == f) step();
        allow_r = 1'b0;
        f = r_falls;
        repeat ((BMAX + 2) * IVL) step();
        chk(r_lostn == 2, "R10 lost pulses", r_lostn, 2);
        chk(r_falls == f, "R9 none while withheld", r_falls, f);
        allow_r = 1'b1;
        repeat (30) step();
        chk(r_falls == f + BMAX, "R10 only backlog served", r_falls, f + BMAX);
        chk(c_lostn == 0, "R10 no loss when granted", c_lostn, 0);
        chk(c_rdy && r_rdy, "R3 ready stays high", c_rdy, 1);
        finish_run();
    end
endmodule